// File: doc/BRIEF.md
# Square-Order Carry-Save Multiplier (16 x 16, unsigned)

This block multiplies two unsigned 16-bit operands and hands back the product in redundant form: a sum vector and a carry vector whose plain binary sum is the exact 32-bit product. No carry-propagate adder is included. A downstream adder, an accumulator or a fused multiply-add stage resolves the two vectors when it needs a single number. The block has no clock and no state. Both output vectors are pure functions of the two operands.

The product is built recursively. Each operand is split into halves, and four half-size products are formed: low by low, high by low, low by high and high by high. The two cross products carry equal weight, so they sit side by side in the reduction order. At the 8 x 8 level, each of the four 4 x 4 leaf products arrives as two vectors. The resulting eight vectors are reduced to two by four levels of 3-to-2 counters. At the 16 x 16 level, the eight vectors from the four 8 x 8 nodes feed one array of 6-to-2 column counters. That array covers the sixteen middle columns (8 to 23), and neighbouring columns are chained through three carry pairs. The sparse bottom eight and top eight columns are each closed by a small ripple adder.

Top module: `sqmul_top`

## Requirements
- R1: For every operand pair, `cs_sum + cs_carry`, evaluated as a 33-bit unsigned addition, equals `op_x * op_y` exactly, with no wrap.
- R2: When either operand is zero, both `cs_sum` and `cs_carry` are all zero.
- R3: Bits 8 down to 0 of `cs_carry` are zero for every operand pair, so the low edge holds one bit per column.
- R4: Bits 31 down to 24 of `cs_carry` are zero for every operand pair, so the high edge holds one bit per column.
- R5: `cs_sum[7:0]` equals bits 7 to 0 of the product for every operand pair.
- R6: With both operands at 16'hFFFF, the two vectors add to 32'hFFFE0001.
- R7: With `op_x` = 2^i and `op_y` = 2^j for any i and j in 0 to 15, the two vectors add to 2^(i+j).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_x | input | 16 | First unsigned multiplicand |
| op_y | input | 16 | Second unsigned multiplicand |
| cs_sum | output | 32 | Sum vector of the carry-save product |
| cs_carry | output | 32 | Carry vector of the carry-save product |

## Verification
The bench sweeps every value of one operand's low byte against a set of patterns in the other operand. It then walks a single set bit through both operands and adds a long run of random pairs, checking the exact 33-bit sum each time. Any dropped carry at the top of a sub-product would show up as a result short by a power of two. A miswired cross-product slot, or a carry pair fed into the wrong neighbouring column, would show up as a result that is off by a shifted partial product. It would be exposed first by single-bit operands and by the all-ones case, which fills every column to its limit. The edge checks on the carry vector catch a design that lets the middle counter array spill into the outer columns. Those columns must stay resolved to one bit each.

// File: rtl/sqmul_pkg.sv
package sqmul_pkg;

    // Reduction slot of a half-size product. Bit 0 selects the high half of
    // the first operand, bit 1 the high half of the second. The two cross
    // products are adjacent because they share one weight.
    typedef enum logic [1:0] {
        SLOT_LL = 2'd0,
        SLOT_HL = 2'd1,
        SLOT_LH = 2'd2,
        SLOT_HH = 2'd3
    } quad_e;

    // One-bit full adder, result {carry, sum}
    function automatic logic [1:0] fa(input logic a, input logic b, input logic c);
        return {(a & b) | (a & c) | (b & c), a ^ b ^ c};
    endfunction

endpackage

// File: rtl/sqmul_leaf.sv
module sqmul_leaf #(
    parameter int unsigned LW = 4
) (
    input  logic [LW-1:0]   a,
    input  logic [LW-1:0]   b,
    output logic [2*LW-1:0] va,
    output logic [2*LW-1:0] vb
);
    localparam int unsigned PW = 2 * LW;

    function automatic logic [PW-1:0] maj_up(input logic [PW-1:0] x,
                                              input logic [PW-1:0] y,
                                              input logic [PW-1:0] z);
        return ((x & y) | (x & z) | (y & z)) << 1;
    endfunction

    logic [PW-1:0] row [LW];

    // AND-gate partial-product matrix, one shifted row per bit of b
    always_comb begin
        for (int r = 0; r < LW; r++) begin
            row[r] = PW'(a & {LW{b[r]}}) << r;
        end
    end

    // Linear chain of 3-to-2 counters, rows folded in one by one
    always_comb begin
        logic [PW-1:0] acc_s;
        logic [PW-1:0] acc_c;
        logic [PW-1:0] nxt_s;
        acc_s = row[0];
        acc_c = row[1];
        for (int r = 2; r < LW; r++) begin
            nxt_s = acc_s ^ acc_c ^ row[r];
            acc_c = maj_up(acc_s, acc_c, row[r]);
            acc_s = nxt_s;
        end
        va = acc_s;
        vb = acc_c;
    end

    always_comb begin
        // R1
        leaf_exact_chk: assert ({1'b0, va} + {1'b0, vb} == (PW+1)'(a) * (PW+1)'(b))
            else $error("leaf vectors do not add to the leaf product");
    end

endmodule

// File: rtl/sqmul_node.sv
module sqmul_node
    import sqmul_pkg::*;
#(
    parameter int unsigned NW = 8
) (
    input  logic [NW-1:0]   a,
    input  logic [NW-1:0]   b,
    output logic [2*NW-1:0] va,
    output logic [2*NW-1:0] vb
);
    localparam int unsigned H  = NW / 2;
    localparam int unsigned PW = 2 * NW;

    function automatic logic [PW-1:0] maj_up(input logic [PW-1:0] x,
                                              input logic [PW-1:0] y,
                                              input logic [PW-1:0] z);
        return ((x & y) | (x & z) | (y & z)) << 1;
    endfunction

    logic [2*H-1:0] qa [4];
    logic [2*H-1:0] qb [4];
    logic [PW-1:0]  term [8];

    for (genvar q = 0; q < 4; q++) begin : g_quad
        localparam quad_e       SLOT = quad_e'(q);
        localparam bit          X_HI = (SLOT == SLOT_HL) || (SLOT == SLOT_HH);
        localparam bit          Y_HI = (SLOT == SLOT_LH) || (SLOT == SLOT_HH);
        localparam int unsigned SH   = (X_HI ? H : 0) + (Y_HI ? H : 0);

        logic [H-1:0] xa;
        logic [H-1:0] yb;

        if (X_HI) begin : g_xh
            assign xa = a[NW-1:H];
        end else begin : g_xl
            assign xa = a[H-1:0];
        end
        if (Y_HI) begin : g_yh
            assign yb = b[NW-1:H];
        end else begin : g_yl
            assign yb = b[H-1:0];
        end

        sqmul_leaf #(.LW(H)) u_leaf (
            .a (xa),
            .b (yb),
            .va(qa[q]),
            .vb(qb[q])
        );

        assign term[2*q]   = PW'(qa[q]) << SH;
        assign term[2*q+1] = PW'(qb[q]) << SH;
    end

    // Eight vectors to two in four counter levels: 8 -> 6 -> 4 -> 3 -> 2
    always_comb begin
        logic [PW-1:0] s0, c0, s1, c1, s2, c2, s3, c3, s4, c4;
        s0 = term[0] ^ term[1] ^ term[2];
        c0 = maj_up(term[0], term[1], term[2]);
        s1 = term[3] ^ term[4] ^ term[5];
        c1 = maj_up(term[3], term[4], term[5]);
        s2 = s0 ^ c0 ^ s1;
        c2 = maj_up(s0, c0, s1);
        s3 = c1 ^ term[6] ^ term[7];
        c3 = maj_up(c1, term[6], term[7]);
        s4 = s2 ^ c2 ^ s3;
        c4 = maj_up(s2, c2, s3);
        va = s4 ^ c4 ^ c3;
        vb = maj_up(s4, c4, c3);
    end

    always_comb begin
        // R1
        node_exact_chk: assert ({1'b0, va} + {1'b0, vb} == (PW+1)'(a) * (PW+1)'(b))
            else $error("node vectors do not add to the node product");
    end

endmodule

// File: rtl/sqmul_colarray.sv
module sqmul_colarray
    import sqmul_pkg::*;
#(
    parameter int unsigned H = 8
) (
    input  logic [2*H-1:0] part [8],
    output logic [4*H-1:0] sv,
    output logic [4*H-1:0] cv
);
    localparam int unsigned W  = 4 * H;
    localparam int unsigned LO = H;
    localparam int unsigned HI = 3 * H;
    localparam int unsigned EW = W - HI;

    logic [HI-1:LO] co1, co2, co3, s_col, c_col;
    logic           lo_carry;
    logic [EW-1:0]  hi_fold;

    // Low edge: only the low-by-low pair lands here
    assign {lo_carry, sv[LO-1:0]} = {1'b0, part[0][LO-1:0]} + {1'b0, part[1][LO-1:0]};

    // Middle band: one 6-to-2 counter per column, three carry pairs chained
    for (genvar j = LO; j < HI; j++) begin : g_col
        logic [5:0] inb;
        logic       ci1, ci2, ci3;
        logic [1:0] f1, f2, f3, f4;

        if (j < 2*H) begin : g_lower
            assign inb = {part[5][j-H], part[4][j-H], part[3][j-H],
                          part[2][j-H], part[1][j],   part[0][j]};
        end else begin : g_upper
            assign inb = {part[7][j-2*H], part[6][j-2*H], part[5][j-H],
                          part[4][j-H],   part[3][j-H],   part[2][j-H]};
        end

        if (j == LO) begin : g_first
            assign ci1 = lo_carry;
            assign ci2 = 1'b0;
            assign ci3 = 1'b0;
        end else begin : g_chain
            assign ci1 = co1[j-1];
            assign ci2 = co2[j-1];
            assign ci3 = co3[j-1];
        end

        assign f1 = fa(inb[0], inb[1], inb[2]);
        assign f2 = fa(inb[3], inb[4], inb[5]);
        assign f3 = fa(f1[0], f2[0], ci1);
        assign f4 = fa(f3[0], ci2, ci3);

        assign co1[j]   = f1[1];
        assign co2[j]   = f2[1];
        assign co3[j]   = f3[1];
        assign s_col[j] = f4[0];
        assign c_col[j] = f4[1];
        assign sv[j]    = s_col[j];

        always_comb begin
            // R1
            col_balance_chk: assert (int'(s_col[j]) + 2 * (int'(c_col[j]) + int'(co1[j])
                                     + int'(co2[j]) + int'(co3[j]))
                                     == $countones(inb) + int'(ci1) + int'(ci2) + int'(ci3))
                else $error("column %0d counter loses weight", j);
        end
    end

    // High edge: high-by-high pair plus everything leaving the top column
    assign hi_fold = EW'(co1[HI-1]) + EW'(co2[HI-1]) + EW'(co3[HI-1]) + EW'(c_col[HI-1]);
    assign sv[W-1:HI] = part[6][2*H-1:H] + part[7][2*H-1:H] + hi_fold;

    // Carry vector: populated only inside the middle band
    for (genvar j = 0; j < W; j++) begin : g_cv
        if (j > LO && j < HI) begin : g_live
            assign cv[j] = c_col[j-1];
        end else begin : g_zero
            assign cv[j] = 1'b0;
        end
    end

endmodule

// File: rtl/sqmul_top.sv
module sqmul_top #(
    parameter int unsigned OP_W = 16
) (
    input  logic [OP_W-1:0]   op_x,
    input  logic [OP_W-1:0]   op_y,
    output logic [2*OP_W-1:0] cs_sum,
    output logic [2*OP_W-1:0] cs_carry
);
    localparam int unsigned HALF = OP_W / 2;
    localparam int unsigned RW   = 2 * OP_W + 1;

    logic [OP_W-1:0] part [8];

    // Slot q: bit 0 picks high half of op_x, bit 1 picks high half of op_y
    for (genvar q = 0; q < 4; q++) begin : g_node
        localparam bit X_HI = (q % 2) == 1;
        localparam bit Y_HI = (q / 2) == 1;

        logic [HALF-1:0] xa;
        logic [HALF-1:0] yb;

        if (X_HI) begin : g_xh
            assign xa = op_x[OP_W-1:HALF];
        end else begin : g_xl
            assign xa = op_x[HALF-1:0];
        end
        if (Y_HI) begin : g_yh
            assign yb = op_y[OP_W-1:HALF];
        end else begin : g_yl
            assign yb = op_y[HALF-1:0];
        end

        sqmul_node #(.NW(HALF)) u_node (
            .a (xa),
            .b (yb),
            .va(part[2*q]),
            .vb(part[2*q+1])
        );
    end

    sqmul_colarray #(.H(HALF)) u_cols (
        .part(part),
        .sv  (cs_sum),
        .cv  (cs_carry)
    );

    always_comb begin
        // R1
        prod_exact_chk: assert ({1'b0, cs_sum} + {1'b0, cs_carry} == RW'(op_x) * RW'(op_y))
            else $error("output vectors do not add to the product");
        // R2
        zero_operand_chk: assert (!(op_x == '0 || op_y == '0) || (cs_sum == '0 && cs_carry == '0))
            else $error("zero operand left residue in the output vectors");
        // R5
        low_byte_chk: assert (cs_sum[HALF-1:0] == (op_x[HALF-1:0] * op_y[HALF-1:0]) % (2**HALF))
            else $error("low edge of the sum vector disagrees with the product");
    end

endmodule

// File: tb/sqmul_top_bench.sv
`timescale 1ns/1ps
module sqmul_top_bench;

    logic        clk = 1'b0;
    logic [15:0] op_x = '0;
    logic [15:0] op_y = '0;
    logic [31:0] cs_sum;
    logic [31:0] cs_carry;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    sqmul_top u_sqmul_top (
        .op_x    (op_x),
        .op_y    (op_y),
        .cs_sum  (cs_sum),
        .cs_carry(cs_carry)
    );

    task automatic check(input string tag, input logic [32:0] got, input logic [32:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s x=%h y=%h actual=%h expected=%h", tag, op_x, op_y, got, exp);
        end
    endtask

    task automatic drive(input logic [15:0] x, input logic [15:0] y);
        @(negedge clk);
        op_x = x;
        op_y = y;
        #1;
    endtask

    // Drives one pair and checks the arithmetic and edge rules
    task automatic run_pair(input string tag, input logic [15:0] x, input logic [15:0] y);
        logic [32:0] prod;
        drive(x, y);
        prod = 33'(x) * 33'(y);
        check(tag, {1'b0, cs_sum} + {1'b0, cs_carry}, prod);           // R1
        check("R3", 33'(cs_carry[8:0]), 33'd0);
        check("R4", 33'(cs_carry[31:24]), 33'd0);
        check("R5", 33'(cs_sum[7:0]), 33'(prod[7:0]));
    endtask

    initial begin
        logic [15:0] ypat [8];
        ypat[0] = 16'h0001; ypat[1] = 16'h00FF; ypat[2] = 16'hFF00; ypat[3] = 16'hFFFF;
        ypat[4] = 16'hAAAA; ypat[5] = 16'h5555; ypat[6] = 16'h8001; ypat[7] = 16'h7FFE;

        // R2: zero operands on either side
        drive(16'h0000, 16'h0000);
        check("R2", {1'b0, cs_sum | cs_carry}, 33'd0);
        drive(16'h0000, 16'hBEEF);
        check("R2", {1'b0, cs_sum | cs_carry}, 33'd0);
        drive(16'hFFFF, 16'h0000);
        check("R2", {1'b0, cs_sum | cs_carry}, 33'd0);

        // R6: every column filled
        drive(16'hFFFF, 16'hFFFF);
        check("R6", {1'b0, cs_sum} + {1'b0, cs_carry}, 33'h0_FFFE_0001);

        // R7: single set bit walked through both operands
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                drive(16'(1) << i, 16'(1) << j);
                check("R7", {1'b0, cs_sum} + {1'b0, cs_carry}, 33'(1) << (i + j));
            end
        end

        // R1: every low byte, shifted into each byte lane, against fixed patterns
        for (int v = 0; v < 256; v++) begin
            for (int p = 0; p < 8; p++) begin
                run_pair("R1", 16'(v), ypat[p]);
                run_pair("R1", ypat[p], 16'(v) << 8);
            end
        end

        // R1: random pairs
        for (int k = 0; k < 6000; k++) begin
            run_pair("R1", 16'($urandom), 16'($urandom));
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule